// File: doc/BRIEF.md
# Pipelined AES-128 Encryption Core

This block encrypts 128-bit data blocks under 128-bit keys with the AES-128 cipher. All ten rounds are unrolled in hardware. Each round is cut into two register stages: one after byte substitution and row rotation, and one after column mixing and key addition. The key schedule is unrolled beside the rounds and cut into the same two stages. Each round key therefore reaches its round in the same cycle as the data that needs it, and the key may change on every block.

A host presents a plaintext and a key together with a valid strobe. It may do so on every clock, with no handshake. The matching ciphertext leaves after a fixed number of cycles with its own valid strobe. Gaps in the input stream come out as the same gaps in the output stream. Reset clears only the valid pipeline. Data registers keep whatever they hold, and their contents are masked by the cleared valid bits.

Top module: `aes128_enc_pipe`

## Requirements
- R1: Input byte k (k = 0..15) occupies bits [127-8k : 120-8k] of `i_pt` and `i_key`. It lands in state row k mod 4, column k div 4, and the ciphertext leaves `o_ct` in the same byte order. With key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734, the output is 3925841d02dc09fbdc118597196a0b32. With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the output is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: For any plaintext and key, including plaintext = key = 000102..0f, `o_ct` equals the AES-128 ciphertext. That cipher is one key addition with the original key, then nine rounds of substitution, row rotation (row r rotated left by r bytes), column mixing and key addition, then a last round with no column mixing. Round constants run 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36.
- R3: A block sampled at rising edge k with `i_valid` high drives `o_valid` high with its ciphertext for exactly the one cycle that follows edge k+20. This makes 21 register stages.
- R4: A new block can be accepted on every clock, each with a different key. Back-to-back blocks do not disturb each other's results.
- R5: While `rst` is high at a rising edge, the valid pipeline is cleared and `i_valid` is ignored. `o_valid` is low after that edge, and blocks in flight at the time never appear.
- R6: `o_valid` is low in every cycle that does not carry an accepted block, so input bubbles are kept in place. `i_pt` and `i_key` have no effect while `i_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| i_valid | input | 1 | Plaintext and key are presented this cycle |
| i_pt | input | 128 | Plaintext block, byte 0 in the top bits |
| i_key | input | 128 | Cipher key for this block, byte 0 in the top bits |
| o_valid | output | 1 | Ciphertext on `o_ct` is valid this cycle |
| o_ct | output | 128 | Ciphertext block, byte 0 in the top bits |

## Verification
The bench targets five kinds of error.

- **Byte order and published vectors.** A swapped byte order or a transposed state would give the wrong published answers.
- **Last round.** A last round that still mixes columns would corrupt every ciphertext while the latency still looked correct.
- **Key stages out of step.** Consecutive blocks each carry a different key. A key stage running one cycle ahead of or behind its round would pair a block with its neighbour's round key and corrupt the whole burst.
- **Valid strobe.** Sparse and bubbled streams would expose a strobe that is shifted, stretched or dropped.
- **Reset in mid-stream.** A reset during a full pipeline would expose stale blocks that leak out once reset is released.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

    localparam int NUM_ROUNDS = 10;
    localparam int BLK_W      = 128;
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int NUM_COLS   = BLK_W / WORD_W;
    localparam int NUM_ROWS   = WORD_W / BYTE_W;
    localparam int PIPE_LAT   = 2 * NUM_ROUNDS + 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  block_t;

    // Multiply by x in GF(2^8) with reduction polynomial 0x11b.
    function automatic byte_t gf_xtime(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Inverse as a^254 = a^(2+4+...+128); maps 0 to 0.
    function automatic byte_t gf_inv(byte_t a);
        byte_t pw;
        byte_t acc;
        pw  = a;
        acc = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            pw  = gf_mul(pw, pw);
            acc = gf_mul(acc, pw);
        end
        return acc;
    endfunction

    function automatic byte_t sbox(byte_t a);
        byte_t v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    function automatic word_t sub_word(word_t w);
        word_t o;
        for (int i = 0; i < NUM_ROWS; i++)
            o[BYTE_W*i +: BYTE_W] = sbox(w[BYTE_W*i +: BYTE_W]);
        return o;
    endfunction

    function automatic word_t rot_word(word_t w);
        return {w[WORD_W-BYTE_W-1:0], w[WORD_W-1 -: BYTE_W]};
    endfunction

    function automatic byte_t round_const(int idx);
        byte_t r;
        r = 8'h01;
        for (int i = 1; i < idx; i++) r = gf_xtime(r);
        return r;
    endfunction

    // Byte at row r, column c of a state held as a flat block.
    function automatic byte_t state_byte(block_t s, int r, int c);
        return s[BLK_W-1-BYTE_W*(r+NUM_ROWS*c) -: BYTE_W];
    endfunction

    function automatic word_t state_col(block_t s, int c);
        return s[BLK_W-1-WORD_W*c -: WORD_W];
    endfunction

    // Byte substitution followed by left rotation of row r by r places.
    function automatic block_t sub_shift(block_t s);
        block_t o;
        for (int r = 0; r < NUM_ROWS; r++)
            for (int c = 0; c < NUM_COLS; c++)
                o[BLK_W-1-BYTE_W*(r+NUM_ROWS*c) -: BYTE_W] =
                    sbox(state_byte(s, r, (c + r) % NUM_COLS));
        return o;
    endfunction

    function automatic word_t mix_word(word_t w);
        byte_t a0, a1, a2, a3;
        byte_t x0, x1, x2, x3;
        a0 = w[31:24]; a1 = w[23:16]; a2 = w[15:8]; a3 = w[7:0];
        x0 = gf_xtime(a0); x1 = gf_xtime(a1);
        x2 = gf_xtime(a2); x3 = gf_xtime(a3);
        return {x0 ^ x1 ^ a1 ^ a2 ^ a3,
                a0 ^ x1 ^ x2 ^ a2 ^ a3,
                a0 ^ a1 ^ x2 ^ x3 ^ a3,
                x0 ^ a0 ^ a1 ^ a2 ^ x3};
    endfunction

endpackage

// File: rtl/aes128_key_step.sv
module aes128_key_step
    import aes128_pkg::*;
#(
    parameter int RC_IDX = 1
) (
    input  logic   clk,
    input  block_t i_key,
    output block_t o_rkey,
    output block_t o_key
);

    localparam byte_t RCON = round_const(RC_IDX);

    typedef struct packed {
        block_t prev;
        word_t  tmp;
        block_t nxt;
    } key_regs_t;

    key_regs_t k_d, k_q;
    block_t    fresh;

    // Second half: chain of column XORs that finishes the new round key.
    always_comb begin
        word_t run;
        run = state_col(k_q.prev, 0) ^ k_q.tmp;
        fresh[BLK_W-1 -: WORD_W] = run;
        for (int c = 1; c < NUM_COLS; c++) begin
            run = run ^ state_col(k_q.prev, c);
            fresh[BLK_W-1-WORD_W*c -: WORD_W] = run;
        end
    end

    // First half: rotate, substitute and add the constant on the last column.
    always_comb begin
        k_d.prev = i_key;
        k_d.tmp  = sub_word(rot_word(state_col(i_key, NUM_COLS-1)))
                 ^ {RCON, {(WORD_W-BYTE_W){1'b0}}};
        k_d.nxt  = fresh;
    end

    always_ff @(posedge clk) begin
        k_q <= k_d;
    end

    assign o_rkey = fresh;
    assign o_key  = k_q.nxt;

endmodule

// File: rtl/aes128_round.sv
module aes128_round
    import aes128_pkg::*;
#(
    parameter bit FINAL = 1'b0
) (
    input  logic   clk,
    input  block_t i_state,
    input  block_t i_rkey,
    output block_t o_state
);

    typedef struct packed {
        block_t mid;
        block_t fin;
    } round_regs_t;

    round_regs_t r_d, r_q;
    block_t      mixed;

    generate
        if (FINAL) begin : g_nomix
            assign mixed = r_q.mid;
        end else begin : g_mix
            always_comb begin
                for (int c = 0; c < NUM_COLS; c++)
                    mixed[BLK_W-1-WORD_W*c -: WORD_W] = mix_word(state_col(r_q.mid, c));
            end
        end
    endgenerate

    always_comb begin
        r_d.mid = sub_shift(i_state);
        r_d.fin = mixed ^ i_rkey;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign o_state = r_q.fin;

endmodule

// File: rtl/aes128_enc_pipe.sv
module aes128_enc_pipe
    import aes128_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_valid,
    input  logic [BLK_W-1:0]     i_pt,
    input  logic [BLK_W-1:0]     i_key,
    output logic                 o_valid,
    output logic [BLK_W-1:0]     o_ct
);

    localparam int CNT_W = $clog2(PIPE_LAT + 1) + 1;

    typedef struct packed {
        block_t st;
        block_t key;
    } head_regs_t;

    head_regs_t          head_d, head_q;
    logic [PIPE_LAT-1:0] vld_d, vld_q;

    block_t st_chain  [0:NUM_ROUNDS];
    block_t key_chain [0:NUM_ROUNDS];
    block_t rkey      [1:NUM_ROUNDS];

    // Entry stage: whitening with the original key, key captured alongside.
    always_comb begin
        head_d.st  = i_pt ^ i_key;
        head_d.key = i_key;
        vld_d      = rst ? '0 : {vld_q[PIPE_LAT-2:0], i_valid};
    end

    always_ff @(posedge clk) begin
        head_q <= head_d;
    end

    always_ff @(posedge clk) begin
        vld_q <= vld_d;
    end

    assign st_chain[0]  = head_q.st;
    assign key_chain[0] = head_q.key;

    generate
        for (genvar g = 1; g <= NUM_ROUNDS; g++) begin : g_round
            aes128_key_step #(
                .RC_IDX (g)
            ) u_key (
                .clk    (clk),
                .i_key  (key_chain[g-1]),
                .o_rkey (rkey[g]),
                .o_key  (key_chain[g])
            );
            aes128_round #(
                .FINAL  (g == NUM_ROUNDS)
            ) u_rnd (
                .clk     (clk),
                .i_state (st_chain[g-1]),
                .i_rkey  (rkey[g]),
                .o_state (st_chain[g])
            );
        end
    endgenerate

    assign o_valid = vld_q[PIPE_LAT-1];
    assign o_ct    = st_chain[NUM_ROUNDS];

    // Occupancy and age counters used only by the assertions below.
    logic [CNT_W-1:0] occ_q, age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
            age_q <= '0;
        end else begin
            occ_q <= occ_q + CNT_W'(i_valid) - CNT_W'(o_valid);
            if (age_q < CNT_W'(PIPE_LAT)) age_q <= age_q + 1'b1;
        end
    end

    assert_reset_clears_R5: assert property (@(posedge clk) rst |=> !o_valid)
        else $error("R5: valid seen after reset edge");

    assert_no_early_out_R3: assert property (@(posedge clk) disable iff (rst)
        (age_q < CNT_W'(PIPE_LAT)) |-> !o_valid)
        else $error("R3: output before pipeline could fill");

    assert_out_has_source_R6: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> (occ_q != '0))
        else $error("R6: output with no accepted block in flight");

    assert_occupancy_bound_R4: assert property (@(posedge clk) disable iff (rst)
        occ_q <= CNT_W'(PIPE_LAT))
        else $error("R4: more blocks in flight than stages");

    assert_ct_known_R2: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> !$isunknown(o_ct))
        else $error("R2: unknown ciphertext while valid");

endmodule

// File: tb/aes128_enc_pipe_tb.sv
`timescale 1ns/1ps
module aes128_enc_pipe_tb_top;

    localparam int LAT = 21;
    localparam int WD_EDGES = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         i_valid = 1'b0;
    logic [127:0] i_pt = '0;
    logic [127:0] i_key = '0;
    logic         o_valid;
    logic [127:0] o_ct;

    aes128_enc_pipe dut_i (
        .clk     (clk),
        .rst     (rst),
        .i_valid (i_valid),
        .i_pt    (i_pt),
        .i_key   (i_key),
        .o_valid (o_valid),
        .o_ct    (o_ct)
    );

    always #10 clk = ~clk;

    typedef struct {
        int           due;
        logic [127:0] ct;
        string        tag;
    } exp_t;

    exp_t   exp_q[$];
    int     edges  = 0;
    int     checks = 0;
    int     errors = 0;
    bit     ended  = 0;
    string  vtag   = "R3";
    logic [7:0] sb [256];

    always @(posedge clk) edges++;

    // Behavioural reference model
    function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= a;
            a = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
        end
        return p;
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] s;
            logic [7:0] cst = 8'h63;
            if (x != 0)
                for (int y = 1; y < 256; y++)
                    if (m_mul(x[7:0], y[7:0]) == 8'h01) inv = y[7:0];
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ cst[i];
            sb[x] = s;
        end
    endtask

    function automatic logic [127:0] ref_enc(logic [127:0] pt, logic [127:0] key);
        logic [7:0] st [16];
        logic [7:0] t  [16];
        logic [7:0] ek [176];
        logic [7:0] tmp [4];
        logic [7:0] rc = 8'h01;
        logic [127:0] res;
        for (int k = 0; k < 16; k++) begin
            st[k] = pt[127-8*k -: 8];
            ek[k] = key[127-8*k -: 8];
        end
        for (int i = 16; i < 176; i += 4) begin
            for (int j = 0; j < 4; j++) tmp[j] = ek[i-4+j];
            if (i % 16 == 0) begin
                logic [7:0] f = tmp[0];
                tmp[0] = sb[tmp[1]] ^ rc;
                tmp[1] = sb[tmp[2]];
                tmp[2] = sb[tmp[3]];
                tmp[3] = sb[f];
                rc = m_mul(rc, 8'h02);
            end
            for (int j = 0; j < 4; j++) ek[i+j] = ek[i-16+j] ^ tmp[j];
        end
        for (int k = 0; k < 16; k++) st[k] ^= ek[k];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int k = 0; k < 16; k++) st[k] = sb[st[k]];
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++)
                    t[r+4*c] = st[r+4*((c+r)%4)];
            for (int c = 0; c < 4; c++) begin
                if (rnd < 10) begin
                    st[4*c+0] = m_mul(t[4*c],8'h02) ^ m_mul(t[4*c+1],8'h03) ^ t[4*c+2] ^ t[4*c+3];
                    st[4*c+1] = t[4*c] ^ m_mul(t[4*c+1],8'h02) ^ m_mul(t[4*c+2],8'h03) ^ t[4*c+3];
                    st[4*c+2] = t[4*c] ^ t[4*c+1] ^ m_mul(t[4*c+2],8'h02) ^ m_mul(t[4*c+3],8'h03);
                    st[4*c+3] = m_mul(t[4*c],8'h03) ^ t[4*c+1] ^ t[4*c+2] ^ m_mul(t[4*c+3],8'h02);
                end else begin
                    for (int r = 0; r < 4; r++) st[4*c+r] = t[4*c+r];
                end
            end
            for (int k = 0; k < 16; k++) st[k] ^= ek[16*rnd+k];
        end
        for (int k = 0; k < 16; k++) res[127-8*k -: 8] = st[k];
        return res;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Per-cycle comparison against the model queue
    always @(negedge clk) begin
        logic         ev;
        logic [127:0] ect;
        string        etag;
        ev = 1'b0; ect = '0; etag = "R2";
        if (exp_q.size() > 0 && exp_q[0].due == edges) begin
            ev = 1'b1; ect = exp_q[0].ct; etag = exp_q[0].tag;
            void'(exp_q.pop_front());
        end
        checks++;
        if (o_valid !== ev) begin
            errors++;
            $display("FAIL %s valid at edge %0d: actual=%b expected=%b", vtag, edges, o_valid, ev);
        end
        if (ev) begin
            checks++;
            if (o_ct !== ect) begin
                errors++;
                $display("FAIL %s ciphertext at edge %0d: actual=%h expected=%h", etag, edges, o_ct, ect);
            end
        end
    end

    task automatic issue(input logic [127:0] pt, input logic [127:0] key,
                         input logic [127:0] ct, input string tag);
        @(negedge clk); #1;
        i_valid = 1'b1; i_pt = pt; i_key = key;
        exp_q.push_back('{due: edges + LAT, ct: ct, tag: tag});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            i_valid = 1'b0; i_pt = rnd128(); i_key = rnd128();
        end
    endtask

    task automatic check_low(input string tag);
        @(negedge clk); #2;
        checks++;
        if (o_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s o_valid: actual=%b expected=0", tag, o_valid);
        end
    endtask

    initial begin
        repeat (WD_EDGES) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [127:0] seq;
        build_sbox();
        // R5: reset state
        repeat (3) @(negedge clk);
        check_low("R5");
        @(negedge clk); #1;
        rst = 1'b0;
        check_low("R5");

        // R1: published vectors, byte order fixed by literal results
        issue(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
              128'h3925841d02dc09fbdc118597196a0b32, "R1");
        issue(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
              128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1");
        // R2: counting-byte plaintext under counting-byte key
        seq = 128'h000102030405060708090a0b0c0d0e0f;
        issue(seq, seq, ref_enc(seq, seq), "R2");
        // R6: idle stretch with changing data, nothing may appear
        vtag = "R6";
        idle(30);

        // R4: back-to-back, a fresh key every cycle
        vtag = "R3";
        for (int i = 0; i < 40; i++) begin
            logic [127:0] p = rnd128();
            logic [127:0] k = rnd128();
            issue(p, k, ref_enc(p, k), "R4");
        end
        idle(LAT + 2);

        // R6: bubbled stream keeps its gaps
        vtag = "R6";
        for (int i = 0; i < 30; i++) begin
            if (i % 3 != 0) begin
                logic [127:0] p = rnd128();
                logic [127:0] k = rnd128();
                issue(p, k, ref_enc(p, k), "R6");
            end else begin
                idle(1);
            end
        end
        idle(LAT + 2);

        // R5: reset with a full pipeline, in-flight blocks dropped
        vtag = "R3";
        for (int i = 0; i < 15; i++) begin
            logic [127:0] p = rnd128();
            logic [127:0] k = rnd128();
            issue(p, k, ref_enc(p, k), "R4");
        end
        @(negedge clk); #1;
        rst = 1'b1; i_valid = 1'b1; i_pt = rnd128(); i_key = rnd128();
        exp_q.delete();
        vtag = "R5";
        @(negedge clk); #1;
        i_pt = rnd128();
        @(negedge clk); #1;
        rst = 1'b0; i_valid = 1'b0;
        idle(LAT + 4);
        check_low("R5");

        // R4: traffic resumes correctly after reset
        vtag = "R3";
        for (int i = 0; i < 6; i++) begin
            logic [127:0] p = rnd128();
            logic [127:0] k = rnd128();
            issue(p, k, ref_enc(p, k), "R4");
        end
        idle(LAT + 3);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R3 pending blocks: actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule